// File: doc/BRIEF.md
# Transfer activation enable registers

This block sits between a set of interrupt sources and a data transfer controller. It decides which of them may start a transfer. Each source has its own activation-enable bit. A source's request reaches the controller only while that bit is set. A separate software register lets software start a transfer directly. That register holds an enable flag and the vector number to go with the request.

Software reaches both registers over a simple single-cycle read/write port. The transfer engine reports back through three status inputs:
- a transfer-ended pulse with the index of the source it served;
- the disable-after-transfer option that applied to that transfer;
- a flag that the programmed transfer count is now used up.

From these the block clears enable bits on its own. The software enable flag cannot be dropped by one stray write. A zero written to it only takes effect after software has read the flag back as one.

Top module: `xfer_act_regs`

## Requirements
- R1: After reset every source enable bit is 0, the software register reads 0x00, and act_req_o, sw_req_o and sw_vec_o are all 0.
- R2: A bus write to address 0 loads wdata_i[n] into the enable bit of source n. A bus read of address 0 returns the eight enable bits on rdata_o in the same cycle.
- R3: A transfer-ended pulse with the disable-after-transfer option at 1 clears the enable bit of the source given by done_src_i on the next clock edge. The other enable bits are left as they were.
- R4: A transfer-ended pulse with count-exhausted at 1 clears the enable bit of the indexed source on the next clock edge, whatever the disable-after-transfer option is.
- R5: A transfer-ended pulse with both the disable-after-transfer option and count-exhausted at 0 leaves every enable bit unchanged.
- R6: A hardware clear and a bus write of 1 may hit the same enable bit in one cycle. In that case the bit ends up 0, and the other written bits still take their written values.
- R7: A bus write to address 1 with wdata_i[7]=1 always sets the software enable flag. The flag reads back in bit 7 of address 1.
- R8: A bus write to address 1 with wdata_i[7]=0 clears the software enable flag only if an earlier read of address 1 returned bit 7 as 1. A successful clear consumes that read, so a later zero write needs a fresh read of 1 before it has effect.
- R9: Bits 6 to 0 of address 1 hold the software vector. Every write to address 1 loads them, with no handshake, including a write whose zero in bit 7 is ignored.
- R10: act_req_o[n] is irq_i[n] AND enable bit n. sw_req_o equals the software enable flag, and sw_vec_o equals the stored vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = source enables, 1 = software register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the access cycle |
| irq_i | input | 8 | Interrupt request per source |
| done_i | input | 1 | Transfer-ended pulse from the engine |
| done_src_i | input | 3 | Source index of the ended transfer |
| dis_after_i | input | 1 | Disable-after-transfer option of that transfer |
| cnt_last_i | input | 1 | Programmed transfer count used up |
| act_req_o | output | 8 | Gated activation request per source |
| sw_req_o | output | 1 | Software activation request |
| sw_vec_o | output | 7 | Vector for the software request |

## Verification
The hardest situation to reach from the ports is the software-flag handshake state, because the read-as-one latch is never visible on any port. The stimulus first tries a zero write with no prior read and checks that the flag stays up. It then reads address 1 while the flag is set, writes zero and checks that the flag drops. Finally it sets the flag again and writes zero once more without a new read, to show that the earlier read was consumed. A second hard case is a register write landing in the same cycle as a hardware clear of the same bit. The bench reaches it by raising done_i on the very clock edge that carries a write of 0xFF.

// File: rtl/xar_pkg.sv
package xar_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned VEC_W    = DATA_W - 1;
  localparam int unsigned ADDR_W   = 1;
  localparam logic [ADDR_W-1:0] ADDR_EN = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_SW = 1'b1;
endpackage

// File: rtl/xar_bus_dec.sv
module xar_bus_dec
  import xar_pkg::*;
#(
  parameter int unsigned NUM_SRC = DATA_W
) (
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_SRC-1:0]  en_i,
  input  logic                sw_flag_i,
  input  logic [VEC_W-1:0]    sw_vec_i,
  output logic                we_en_o,
  output logic                we_sw_o,
  output logic                rd_sw_o,
  output logic [DATA_W-1:0]   rdata_o
);
  always_comb begin
    we_en_o = sel_i && wr_i && (addr_i == ADDR_EN);
    we_sw_o = sel_i && wr_i && (addr_i == ADDR_SW);
    rd_sw_o = sel_i && !wr_i && (addr_i == ADDR_SW);
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      if (addr_i == ADDR_EN) rdata_o[NUM_SRC-1:0] = en_i;
      else                   rdata_o = {sw_flag_i, sw_vec_i};
    end
  end
endmodule

// File: rtl/xar_src_en.sv
module xar_src_en
  import xar_pkg::*;
#(
  parameter int unsigned NUM_SRC = DATA_W,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic               done_i,
  input  logic [IDX_W-1:0]   done_src_i,
  input  logic               dis_after_i,
  input  logic               cnt_last_i,
  output logic [NUM_SRC-1:0] en_o
);
  logic hw_clr;
  assign hw_clr = done_i && (dis_after_i || cnt_last_i);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic clr;
    assign clr = hw_clr && (done_src_i == IDX_W'(i));
    // hardware clear takes precedence over a bus write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_o[i] <= 1'b0;
      else if (clr)  en_o[i] <= 1'b0;
      else if (we_i) en_o[i] <= wdata_i[i];
    end
  end
endmodule

// File: rtl/xar_sw_reg.sv
module xar_sw_reg
  import xar_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              flag_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              rd_seen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o    <= 1'b0;
      vec_o     <= '0;
      rd_seen_o <= 1'b0;
    end else if (we_i) begin
      vec_o <= wdata_i[VEC_W-1:0];
      if (wdata_i[DATA_W-1]) begin
        flag_o <= 1'b1;
      end else if (rd_seen_o) begin
        flag_o    <= 1'b0;
        rd_seen_o <= 1'b0;
      end
    end else if (rd_i && flag_o) begin
      rd_seen_o <= 1'b1;
    end
  end
endmodule

// File: rtl/xfer_act_regs.sv
module xfer_act_regs
  import xar_pkg::*;
#(
  parameter int unsigned NUM_SRC = DATA_W,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               done_i,
  input  logic [IDX_W-1:0]   done_src_i,
  input  logic               dis_after_i,
  input  logic               cnt_last_i,
  output logic [NUM_SRC-1:0] act_req_o,
  output logic               sw_req_o,
  output logic [VEC_W-1:0]   sw_vec_o
);
  logic [NUM_SRC-1:0] en_q;
  logic               sw_flag;
  logic               sw_rd_seen;
  logic               we_en, we_sw, rd_sw;

  xar_bus_dec #(.NUM_SRC(NUM_SRC)) u_dec (
    .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
    .en_i(en_q), .sw_flag_i(sw_flag), .sw_vec_i(sw_vec_o),
    .we_en_o(we_en), .we_sw_o(we_sw), .rd_sw_o(rd_sw), .rdata_o(rdata_o)
  );

  xar_src_en #(.NUM_SRC(NUM_SRC)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_en),
    .wdata_i(wdata_i[NUM_SRC-1:0]), .done_i(done_i),
    .done_src_i(done_src_i), .dis_after_i(dis_after_i),
    .cnt_last_i(cnt_last_i), .en_o(en_q)
  );

  xar_sw_reg u_sw (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_sw), .rd_i(rd_sw),
    .wdata_i(wdata_i), .flag_o(sw_flag), .vec_o(sw_vec_o),
    .rd_seen_o(sw_rd_seen)
  );

  assign act_req_o = irq_i & en_q;
  assign sw_req_o  = sw_flag;
endmodule

// File: rtl/xar_checker.sv
module xar_checker
  import xar_pkg::*;
#(
  parameter int unsigned NUM_SRC = DATA_W,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sel_i,
  input logic               wr_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [NUM_SRC-1:0] irq_i,
  input logic               done_i,
  input logic [IDX_W-1:0]   done_src_i,
  input logic               dis_after_i,
  input logic               cnt_last_i,
  input logic [NUM_SRC-1:0] act_req_o,
  input logic               sw_req_o,
  input logic [VEC_W-1:0]   sw_vec_o,
  input logic [NUM_SRC-1:0] en_q,
  input logic               sw_rd_seen
);
  logic wr_sw;
  assign wr_sw = sel_i && wr_i && (addr_i == ADDR_SW);

  // R3 R4 R6
  a_r3_hw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && (dis_after_i || cnt_last_i) |=> !en_q[$past(done_src_i)]);

  // R5
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i && addr_i == ADDR_EN) && !(done_i && (dis_after_i || cnt_last_i))
    |=> $stable(en_q));

  a_r7_set_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sw && wdata_i[DATA_W-1] |=> sw_req_o);

  a_r8_zero_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sw && !wdata_i[DATA_W-1] && !sw_rd_seen |=> sw_req_o == $past(sw_req_o));

  a_r9_vec_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sw |=> sw_vec_o == $past(wdata_i[VEC_W-1:0]));

  a_r10_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_req_o & ~(irq_i & en_q)) == '0);
endmodule

bind xfer_act_regs xar_checker #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/sim_xfer_act_regs.sv
`timescale 1ns/1ps
module sim_xfer_act_regs;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0, wr_i = 1'b0;
  logic [0:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] irq_i = '0;
  logic       done_i = 1'b0;
  logic [2:0] done_src_i = '0;
  logic       dis_after_i = 1'b0, cnt_last_i = 1'b0;
  logic [7:0] act_req_o;
  logic       sw_req_o;
  logic [6:0] sw_vec_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  xfer_act_regs u0 (.*);

  // {enable write, irq, expected act_req}
  localparam logic [23:0] VECS [6] = '{
    24'hFF_00_00, 24'hFF_A5_A5, 24'h0F_FF_0F,
    24'h3C_66_24, 24'h00_FF_00, 24'h81_81_81
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 0; wr_i = 0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1; wr_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    sel_i = 0;
  endtask

  task automatic pulse_done(input logic [2:0] s, input logic dis, input logic last);
    @(negedge clk_i);
    done_i = 1; done_src_i = s; dis_after_i = dis; cnt_last_i = last;
    @(negedge clk_i);
    done_i = 0; dis_after_i = 0; cnt_last_i = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    #12 rst_ni = 1;
    // R1
    bus_rd(0, rd); check("R1 enables", rd, 8'h00);
    bus_rd(1, rd); check("R1 sw reg", rd, 8'h00);
    check("R1 act_req", act_req_o, 8'h00);
    check("R1 sw_req/vec", {sw_req_o, sw_vec_o}, 8'h00);

    // R2 R10 table
    for (int i = 0; i < 6; i++) begin
      bus_wr(0, VECS[i][23:16]);
      irq_i = VECS[i][15:8];
      #1 check("R10 act_req", act_req_o, VECS[i][7:0]);
      bus_rd(0, rd); check("R2 readback", rd, VECS[i][23:16]);
    end
    irq_i = '0;

    bus_wr(0, 8'hFF);
    pulse_done(3'd3, 1'b1, 1'b0);
    bus_rd(0, rd); check("R3 dis-after clear", rd, 8'hF7);
    pulse_done(3'd0, 1'b0, 1'b1);
    bus_rd(0, rd); check("R4 count clear", rd, 8'hF6);
    pulse_done(3'd5, 1'b0, 1'b0);
    bus_rd(0, rd); check("R5 hold", rd, 8'hF6);

    // R6: write FF with clear of source 7 in the same cycle
    @(negedge clk_i);
    sel_i = 1; wr_i = 1; addr_i = 0; wdata_i = 8'hFF;
    done_i = 1; done_src_i = 3'd7; dis_after_i = 1;
    @(negedge clk_i);
    sel_i = 0; wr_i = 0; done_i = 0; dis_after_i = 0;
    bus_rd(0, rd); check("R6 clear wins", rd, 8'h7F);

    // R7
    bus_wr(1, 8'h92);
    check("R7 sw_req", {7'd0, sw_req_o}, 8'h01);
    check("R10 sw_vec", {1'b0, sw_vec_o}, 8'h12);
    // R8 without read, R9 vector still loads
    bus_wr(1, 8'h00);
    check("R8 zero ignored", {7'd0, sw_req_o}, 8'h01);
    check("R9 vec free", {1'b0, sw_vec_o}, 8'h00);
    bus_rd(1, rd); check("R7 readback", rd, 8'h80);
    bus_wr(1, 8'h05);
    check("R8 zero after read", {7'd0, sw_req_o}, 8'h00);
    check("R9 vec", {1'b0, sw_vec_o}, 8'h05);
    bus_wr(1, 8'h80);
    bus_wr(1, 8'h00);
    check("R8 read consumed", {7'd0, sw_req_o}, 8'h01);
    bus_rd(1, rd); check("R9 readback", rd, 8'h80);
    bus_wr(1, 8'h2A);
    bus_rd(1, rd); check("R8 second clear", rd, 8'h2A);

    finish_run();
  end
endmodule